// File: doc/BRIEF.md
# Cascaded Shift-Only EWMA Shaping Filter

This block smooths a stream of signed 14-bit digitizer samples before a pulse-amplitude stage reads them. It chains six first-order exponential moving-average sections. Each section moves its state toward its input by a power-of-two fraction of the difference, so the whole sixth-order low-pass response uses only adders and arithmetic shifts, with no multipliers.

Every section holds six fractional bits below the sample LSB, so the truncation inside the shift does not build up across the chain. A 3-bit port selects the shift. A synchronous clear loads every section with the sample currently on the input, so a steady baseline shows up at the output at once instead of ramping up from zero. The last state is rounded back to 14 bits and limited to the signed range.

Top module: `ewma_shaper`

## Requirements
- R1: After the synchronous reset, `out_valid` is 0 and `out_sample` is 0 until data is accepted.
- R2: Each section keeps a 20-bit state, which is the sample scaled by 64. On a cycle when its input is valid, it updates as state <= state + floor((input - state) / 2^k), where the division is an arithmetic right shift by k. Section 0 takes `in_sample` scaled by 64, and section i takes the state of section i-1.
- R3: A sample accepted at clock edge n gives `out_valid` high just after edge n+5, which is six edges counting the accepting edge. The valid pattern keeps its spacing through the chain.
- R4: On cycles without a valid input, the section states do not change. Once the chain drains, `out_valid` stays 0 and `out_sample` holds its last value, whatever `in_sample` does.
- R5: While `clr` is high, every section state loads `in_sample` scaled by 64 and every pending valid is dropped. `clr` takes priority over `in_valid`. A constant input presented after a clear comes out exactly unchanged.
- R6: `shift_sel` gives k. The values 1 to 6 are used as they are, 0 acts as 1, and 7 acts as 6.
- R7: `out_sample` = floor((last state + 32) / 64), saturated to the range -8192..8191.
- R8: After a valid update, each section state lies between its previous state and its input, both ends included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Load all section states with the current input sample |
| in_valid | input | 1 | `in_sample` holds a new sample |
| in_sample | input | 14 | Signed input sample |
| shift_sel | input | 3 | Shift amount k (0 acts as 1, 7 acts as 6) |
| out_valid | output | 1 | `out_sample` holds a new filtered sample |
| out_sample | output | 14 | Rounded, saturated filtered sample |

## Verification
A sample that enters at one edge reaches the output six edges later. The flush caused by a clear shows up after the next edge. The bench's behavioural model advances its six integer states at the same edge as the design, and it compares both outputs at the following falling edge on every cycle.

The latency check counts falling edges after an isolated valid and expects `out_valid` only at the sixth. The settle checks at the range limits and the hold checks wait until the chain has drained before they sample a value.

// File: rtl/ewma_pkg.sv
package ewma_pkg;

    localparam int DATA_W = 14;
    localparam int FRAC_W = 6;
    localparam int ST_W   = DATA_W + FRAC_W;
    localparam int SH_W   = 3;
    localparam int K_MIN  = 1;
    localparam int K_MAX  = FRAC_W;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [ST_W-1:0]   state_t;

    typedef struct packed {
        logic   vld;
        state_t val;
    } tap_t;

    function automatic logic [SH_W-1:0] clamp_shift(input logic [SH_W-1:0] k);
        if (k < SH_W'(K_MIN))
            return SH_W'(K_MIN);
        else if (k > SH_W'(K_MAX))
            return SH_W'(K_MAX);
        else
            return k;
    endfunction

    function automatic state_t widen(input sample_t s);
        return state_t'({s, {FRAC_W{1'b0}}});
    endfunction

endpackage

// File: rtl/ewma_stage.sv
module ewma_stage
    import ewma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  state_t          load_val,
    input  tap_t            tap_in,
    input  logic [SH_W-1:0] shift,
    output tap_t            tap_out
);

    state_t              acc;
    logic                vld_q;
    logic signed [ST_W:0] diff;
    logic signed [ST_W:0] step;
    state_t              nxt;

    always_comb begin
        diff = {tap_in.val[ST_W-1], tap_in.val} - {acc[ST_W-1], acc};
        step = diff >>> shift;
        nxt  = acc + state_t'(step[ST_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            vld_q <= 1'b0;
        end else if (clr) begin
            acc   <= load_val;
            vld_q <= 1'b0;
        end else begin
            vld_q <= tap_in.vld;
            if (tap_in.vld)
                acc <= nxt;
        end
    end

    always_comb begin
        tap_out.vld = vld_q;
        tap_out.val = acc;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tap_in.vld) |=> $stable(acc)); // R4

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!clr && tap_in.vld) |=>
            (((acc >= $past(acc)) && (acc <= $past(tap_in.val))) ||
             ((acc <= $past(acc)) && (acc >= $past(tap_in.val))))); // R8

    AST_CLR_LOAD: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((acc == $past(load_val)) && !vld_q)); // R5

endmodule

// File: rtl/ewma_round.sv
module ewma_round
    import ewma_pkg::*;
(
    input  state_t  val,
    output sample_t q
);

    localparam int Q_W = ST_W - FRAC_W + 1;
    localparam logic signed [Q_W-1:0] HI = Q_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [Q_W-1:0] LO = -Q_W'(2 ** (DATA_W - 1));
    localparam logic signed [ST_W:0]  HALF = (ST_W + 1)'(2 ** (FRAC_W - 1));

    logic signed [ST_W:0]  biased;
    logic signed [Q_W-1:0] shr;

    always_comb begin
        biased = {val[ST_W-1], val} + HALF;
        shr    = biased[ST_W:FRAC_W];
        if (shr > HI)
            q = sample_t'(HI[DATA_W-1:0]);
        else if (shr < LO)
            q = sample_t'(LO[DATA_W-1:0]);
        else
            q = sample_t'(shr[DATA_W-1:0]);
    end

endmodule

// File: rtl/ewma_shaper.sv
module ewma_shaper
    import ewma_pkg::*;
#(
    parameter int N_STAGES = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [SH_W-1:0]          shift_sel,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);

    tap_t            chain [0:N_STAGES];
    logic [SH_W-1:0] k_eff;
    state_t          load_val;

    assign k_eff       = clamp_shift(shift_sel);
    assign load_val    = widen(in_sample);
    assign chain[0]    = '{vld: in_valid, val: load_val};

    generate
        for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
            ewma_stage u_stage (
                .clk      (clk),
                .rst      (rst),
                .clr      (clr),
                .load_val (load_val),
                .tap_in   (chain[i]),
                .shift    (k_eff),
                .tap_out  (chain[i+1])
            );
        end
    endgenerate

    ewma_round u_round (
        .val (chain[N_STAGES].val),
        .q   (out_sample)
    );

    assign out_valid = chain[N_STAGES].vld;

    AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        clr |=> !out_valid); // R5

    AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(clr)); // R3

endmodule

// File: tb/ewma_shaper_tb.sv
module ewma_shaper_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [13:0] in_sample = '0;
    logic [2:0]        shift_sel = 3'd3;
    logic              out_valid;
    logic signed [13:0] out_sample;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string req = "R2";

    longint m_st [6];
    bit     m_v  [6];

    always #2 clk = ~clk;

    ewma_shaper u_dut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .shift_sel  (shift_sel),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic int clampk(input int k);
        if (k < 1) return 1;
        if (k > 6) return 6;
        return k;
    endfunction

    function automatic longint exp_out();
        longint r;
        r = (m_st[5] + 64'sd32) >>> 6;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    // behavioural model: six integer states advanced on each edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 6; i++) begin
                m_st[i] = 0;
                m_v[i]  = 1'b0;
            end
        end else if (clr) begin
            for (int i = 0; i < 6; i++) begin
                m_st[i] = longint'(in_sample) * 64;
                m_v[i]  = 1'b0;
            end
        end else begin
            for (int i = 5; i >= 0; i--) begin
                longint xin;
                bit     vin;
                xin = (i == 0) ? longint'(in_sample) * 64 : m_st[i-1];
                vin = (i == 0) ? in_valid : m_v[i-1];
                m_v[i] = vin;
                if (vin)
                    m_st[i] = m_st[i] + ((xin - m_st[i]) >>> clampk(int'(shift_sel)));
            end
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int d, input bit c);
        @(negedge clk);
        if (!rst) begin
            check(out_valid == m_v[5], req, "out_valid", longint'(out_valid), longint'(m_v[5]));
            check(longint'(out_sample) == exp_out(), req, "out_sample",
                  longint'(out_sample), exp_out());
        end
        in_valid  = v;
        in_sample = 14'(d);
        clr       = c;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint held;
        repeat (3) cyc(0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
        check(out_sample == 0, "R1", "out_sample", longint'(out_sample), 0);

        // R5: constant baseline after clear passes exactly
        req = "R5";
        shift_sel = 3'd3;
        cyc(0, 1000, 1);
        for (int i = 0; i < 20; i++) begin
            cyc(1, 1000, 0);
            if (out_valid)
                check(out_sample == 1000, "R5", "baseline", longint'(out_sample), 1000);
        end

        // R3: isolated sample latency
        req = "R3";
        cyc(0, 0, 1);
        cyc(1, 640, 0);
        for (int i = 1; i <= 8; i++) begin
            cyc(0, 0, 0);
            check(out_valid == (i == 6), "R3", "latency out_valid",
                  longint'(out_valid), longint'(i == 6));
        end

        // R2: random stream with random valid gaps
        req = "R2";
        shift_sel = 3'd2;
        for (int i = 0; i < 300; i++)
            cyc(($urandom % 3) != 0, int'($urandom % 16384) - 8192, 0);

        // R6: shift 0 acts as 1
        req = "R6";
        shift_sel = 3'd0;
        cyc(0, 0, 1);
        cyc(1, 6400, 0);
        for (int i = 1; i <= 6; i++) cyc(0, 0, 0);
        check(out_sample == 100, "R6", "shift 0 impulse", longint'(out_sample), 100);
        for (int i = 0; i < 150; i++)
            cyc(($urandom % 2) != 0, int'($urandom % 16384) - 8192, 0);
        shift_sel = 3'd7;
        for (int i = 0; i < 150; i++)
            cyc(($urandom % 2) != 0, int'($urandom % 16384) - 8192, 0);

        // R7: range limits
        req = "R7";
        shift_sel = 3'd1;
        cyc(0, -8192, 1);
        for (int i = 0; i < 200; i++) cyc(1, 8191, 0);
        check(out_sample == 8191, "R7", "settle high", longint'(out_sample), 8191);
        cyc(0, 8191, 1);
        for (int i = 0; i < 200; i++) cyc(1, -8192, 0);
        check(out_sample == -8192, "R7", "settle low", longint'(out_sample), -8192);

        // R4: idle cycles leave the output frozen
        req = "R4";
        shift_sel = 3'd4;
        for (int i = 0; i < 20; i++) cyc(1, int'($urandom % 16384) - 8192, 0);
        for (int i = 0; i < 7; i++) cyc(0, int'($urandom % 16384) - 8192, 0);
        held = longint'(out_sample);
        for (int i = 0; i < 10; i++) begin
            cyc(0, int'($urandom % 16384) - 8192, 0);
            check(out_valid == 1'b0, "R4", "idle out_valid", longint'(out_valid), 0);
            check(longint'(out_sample) == held, "R4", "idle hold", longint'(out_sample), held);
        end

        // R5: clear beats a simultaneous valid
        req = "R5";
        cyc(1, 2000, 1);
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 0);
            check(out_valid == 1'b0, "R5", "flush", longint'(out_valid), 0);
        end
        check(out_sample == 2000, "R5", "clear load", longint'(out_sample), 2000);

        cyc(0, 0, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule